// File: doc/BRIEF.md
# Indirect-Pointer Serial Register Bank

This block is the byte-wide bus front end of a two-channel serial controller. Each channel has one control port and one data port. Behind each control port sit sixteen write registers and a small set of read registers. A pointer selects which register the next control access reaches. Data-port traffic is not stored here: it is handed straight to the channel datapath as strobes, a channel number and a byte. The datapath's receive byte is returned on data reads.

The pointer is a two-state machine per channel. `PTR_BASE` means the pointer is zero. `PTR_SEL` means a non-zero register is selected. The transition `BASE->SEL` happens on a control write whose pointer field (optionally raised by the point-high command) is non-zero. A control write in `BASE` whose resulting pointer is zero stays in `BASE`. The transition `SEL->BASE` happens on any control write in `SEL`, on any control read in either state, and on a reset of that channel.

A write to register 9 with a non-zero reset field starts a soft reset of one channel or a hard reset of both. Either reset restores a fixed set of bit masks. The block also derives each channel's line format from its write registers: data bits, parity, stop bits and the full baud divisor. These appear as registered outputs for the shifters.

Top module: `serial_regbank`

## Requirements
- R1: After power-on reset every write register of both channels is 0x00, read register 0 reads 0x04 and read register 1 reads 0x00.
- R2: A control write while the pointer is 0 stores the byte in write register 0 and loads bits 2:0 as the next pointer. When bits 5:3 equal 001 (point high), 8 is added to that pointer.
- R3: A control write with a non-zero pointer stores the byte in the selected write register and returns the pointer to 0. A control read returns the selected read register and then returns the pointer to 0. Read registers 0, 1, 12 and 13 are held; every other read register reads 0x00.
- R4: The port bit is address bit REG_SHIFT (0 = control, 1 = data) and the channel bit is address bit REG_SHIFT+1. With SWAP=1 the two positions are exchanged. A data write pulses `data_wr_stb` with `data_ch` and `data_wbyte` in the access cycle. A data read pulses `data_rd_stb` and returns `data_rbyte[ch]`.
- R5: A soft reset clears write register 0 and keeps only bits 0x24 of register 1. It clears bit 0 of register 3, sets bit 0x04 of register 4, and keeps only bits 0x61 of register 5. It clears bit 0x20 of register 9, keeps only bits 0x60 of register 10, and keeps bits 0xC3 of register 14 and sets 0x20. It sets register 15 to 0xF8. It keeps bits 0xB8 of read register 0 and sets 0x44, and keeps bit 0x01 of read register 1 and sets 0x06. It clears that channel's pointer.
- R6: A hard reset does the soft reset on both channels. It then sets register 9 to (reg9 & 0x03) | 0xC0, clears register 10, sets register 11 to 0x08, and sets register 14 to (reg14 & 0xC0) | 0x30.
- R7: A control write to register 9 with bits 7:6 = 01 soft-resets channel 0, 10 soft-resets channel 1, and 11 hard-resets both. Such a write is not stored. It leaves the writing channel's pointer unchanged unless that channel is itself reset. With bits 7:6 = 00 the byte is stored.
- R8: A write to register 4 sets bit 0 of read register 1. Writes to registers 12 and 13 are also held as read registers 12 and 13.
- R9: A write to register 3 with bit 4 set sets bit 4 of read register 0.
- R10: Register 5 bits 6:5 select the data bits (00->5, 01->7, 10->6, 11->8). Register 4 bit 0 enables parity and bit 1 selects even parity. Register 4 bits 3:2 = 11 selects two stop bits. The outputs follow one clock after the register takes the write.
- R11: `line_div` equals (time constant + 2) shifted left by 0, 4, 5 or 6 for register 4 bits 7:6 = 00, 01, 10, 11. The time constant is register 13 (high byte) and register 12 (low byte). The output follows one clock after the register takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid during a read access |
| data_wr_stb | output | 1 | Data-port write toward the datapath |
| data_rd_stb | output | 1 | Data-port read toward the datapath |
| data_ch | output | 1 | Channel of the current access |
| data_wbyte | output | 8 | Byte of a data-port write |
| data_rbyte | input | 2x8 | Receive byte of each channel |
| chan_wregs | output | 2x16x8 | Write registers of both channels |
| line_data_bits | output | 2x4 | Data bits per character |
| line_parity_en | output | 2 | Parity enabled |
| line_parity_even | output | 2 | Even parity selected |
| line_two_stop | output | 2 | Two stop bits selected |
| line_div | output | 2xDIV_W | Full baud divisor |

## Verification
Two behaviours can land in the same cycle. A register-9 write from one channel that resets only the other channel also applies pointer sequencing to the writing channel. The bench issues such a write from channel 0, checks the reset masks on channel 1, and then sends a second control byte on channel 0. That byte is expected to land in register 9, which proves the writer's pointer stayed put. A hard reset likewise coincides with the line-format recompute: the line outputs are checked against the reset-restored registers one clock later.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;

    typedef enum logic {
        PTR_BASE,
        PTR_SEL
    } ptr_state_e;

    localparam int NREG = 16;

    localparam logic [2:0] CMD_POINT_HIGH = 3'b001;

    localparam logic [3:0] REG_RXCFG  = 4'd3;
    localparam logic [3:0] REG_FMT    = 4'd4;
    localparam logic [3:0] REG_RESET  = 4'd9;
    localparam logic [3:0] REG_TC_LO  = 4'd12;
    localparam logic [3:0] REG_TC_HI  = 4'd13;

    localparam logic [7:0] RR0_POWERON = 8'h04;
    localparam logic [7:0] RR0_KEEP    = 8'hB8;
    localparam logic [7:0] RR0_SET     = 8'h44;
    localparam logic [7:0] RR1_KEEP    = 8'h01;
    localparam logic [7:0] RR1_SET     = 8'h06;
    localparam logic [7:0] HUNT_BIT    = 8'h10;

endpackage

// File: rtl/srb_addr_decode.sv
module srb_addr_decode #(
    parameter int ADDR_W    = 4,
    parameter int REG_SHIFT = 0,
    parameter bit SWAP      = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              port_data,
    output logic              chan
);
    generate
        if (SWAP) begin : g_swapped
            assign port_data = addr[REG_SHIFT+1];
            assign chan      = addr[REG_SHIFT];
        end else begin : g_plain
            assign port_data = addr[REG_SHIFT];
            assign chan      = addr[REG_SHIFT+1];
        end
    endgenerate
endmodule

// File: rtl/srb_chan_regs.sv
module srb_chan_regs
    import serial_regbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic                 ctrl_rd,
    input  logic [7:0]           wdata,
    input  logic                 soft_rst,
    input  logic                 hard_rst,
    output logic [NREG-1:0][7:0] wregs,
    output logic [7:0]           rr1,
    output logic [3:0]           ptr,
    output logic [7:0]           ctrl_rdata
);
    ptr_state_e state_q, state_d;
    logic [3:0] sel_q, sel_d;
    logic [7:0] rr0, rr12, rr13;
    logic       any_rst;

    assign any_rst = soft_rst | hard_rst;
    assign ptr     = (state_q == PTR_SEL) ? sel_q : 4'd0;

    // next pointer state
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        if (any_rst || ctrl_rd) begin
            state_d = PTR_BASE;
            sel_d   = 4'd0;
        end else if (ctrl_wr) begin
            unique case (state_q)
                PTR_BASE: begin
                    sel_d   = {wdata[5:3] == CMD_POINT_HIGH, wdata[2:0]};
                    state_d = (sel_d != 4'd0) ? PTR_SEL : PTR_BASE;
                end
                PTR_SEL: begin
                    sel_d   = 4'd0;
                    state_d = PTR_BASE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PTR_BASE;
            sel_q   <= 4'd0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // register outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) wregs[i] <= 8'h00;
            rr0  <= RR0_POWERON;
            rr1  <= 8'h00;
            rr12 <= 8'h00;
            rr13 <= 8'h00;
        end else if (any_rst) begin
            wregs[0]  <= 8'h00;
            wregs[1]  <= wregs[1] & 8'h24;
            wregs[3]  <= wregs[3] & 8'hFE;
            wregs[4]  <= wregs[4] | 8'h04;
            wregs[5]  <= wregs[5] & 8'h61;
            wregs[15] <= 8'hF8;
            rr0       <= (rr0 & RR0_KEEP) | RR0_SET;
            rr1       <= (rr1 & RR1_KEEP) | RR1_SET;
            if (hard_rst) begin
                wregs[9]  <= (wregs[9] & 8'h03) | 8'hC0;
                wregs[10] <= 8'h00;
                wregs[11] <= 8'h08;
                wregs[14] <= (wregs[14] & 8'hC0) | 8'h30;
            end else begin
                wregs[9]  <= wregs[9] & 8'hDF;
                wregs[10] <= wregs[10] & 8'h60;
                wregs[14] <= (wregs[14] & 8'hC3) | 8'h20;
            end
        end else if (ctrl_wr) begin
            unique case (state_q)
                PTR_BASE: wregs[0] <= wdata;
                PTR_SEL: begin
                    wregs[sel_q] <= wdata;
                    if (sel_q == REG_RXCFG && (wdata & HUNT_BIT) != 8'h00)
                        rr0 <= rr0 | HUNT_BIT;
                    if (sel_q == REG_FMT)   rr1  <= rr1 | 8'h01;
                    if (sel_q == REG_TC_LO) rr12 <= wdata;
                    if (sel_q == REG_TC_HI) rr13 <= wdata;
                end
            endcase
        end
    end

    always_comb begin
        unique case (ptr)
            4'd0:      ctrl_rdata = rr0;
            4'd1:      ctrl_rdata = rr1;
            REG_TC_LO: ctrl_rdata = rr12;
            REG_TC_HI: ctrl_rdata = rr13;
            default:   ctrl_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/srb_line_calc.sv
module srb_line_calc #(
    parameter int DIV_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_mode,
    input  logic             par_en_bit,
    input  logic             par_even_bit,
    input  logic [1:0]       stop_field,
    input  logic [1:0]       bits_field,
    input  logic [15:0]      time_const,
    output logic [3:0]       data_bits,
    output logic             parity_en,
    output logic             parity_even,
    output logic             two_stop,
    output logic [DIV_W-1:0] div
);
    logic [2:0]       shift;
    logic [DIV_W-1:0] base;

    always_comb begin
        unique case (clk_mode)
            2'b00: shift = 3'd0;
            2'b01: shift = 3'd4;
            2'b10: shift = 3'd5;
            2'b11: shift = 3'd6;
        endcase
        base = DIV_W'(time_const) + DIV_W'(2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_bits   <= 4'd0;
            parity_en   <= 1'b0;
            parity_even <= 1'b0;
            two_stop    <= 1'b0;
            div         <= '0;
        end else begin
            unique case (bits_field)
                2'b00: data_bits <= 4'd5;
                2'b01: data_bits <= 4'd7;
                2'b10: data_bits <= 4'd6;
                2'b11: data_bits <= 4'd8;
            endcase
            parity_en   <= par_en_bit;
            parity_even <= par_even_bit;
            two_stop    <= (stop_field == 2'b11);
            div         <= base << shift;
        end
    end
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
    import serial_regbank_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int REG_SHIFT = 0,
    parameter bit SWAP      = 1'b0,
    localparam int DIV_W    = 16 + 1 + 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    output logic                      data_wr_stb,
    output logic                      data_rd_stb,
    output logic                      data_ch,
    output logic [7:0]                data_wbyte,
    input  logic [1:0][7:0]           data_rbyte,
    output logic [1:0][NREG-1:0][7:0] chan_wregs,
    output logic [1:0][3:0]           line_data_bits,
    output logic [1:0]                line_parity_en,
    output logic [1:0]                line_parity_even,
    output logic [1:0]                line_two_stop,
    output logic [1:0][DIV_W-1:0]     line_div
);
    logic            acc_data, acc_ch, ctrl_acc, rst_req_wr, hard_req;
    logic [1:0]      soft_req, ctrl_wr_c, ctrl_rd_c;
    logic [1:0][3:0] ptr_c;
    logic [1:0][7:0] rr1_c, ctrl_rdata_c;

    srb_addr_decode #(
        .ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT), .SWAP(SWAP)
    ) u_decode (
        .addr(bus_addr), .port_data(acc_data), .chan(acc_ch)
    );

    assign ctrl_acc   = bus_sel && !acc_data;
    assign rst_req_wr = ctrl_acc && bus_wr && (ptr_c[acc_ch] == REG_RESET)
                        && (bus_wdata[7:6] != 2'b00);
    assign soft_req[0] = rst_req_wr && (bus_wdata[7:6] == 2'b01);
    assign soft_req[1] = rst_req_wr && (bus_wdata[7:6] == 2'b10);
    assign hard_req    = rst_req_wr && (bus_wdata[7:6] == 2'b11);

    assign data_wr_stb = bus_sel && acc_data && bus_wr;
    assign data_rd_stb = bus_sel && acc_data && !bus_wr;
    assign data_ch     = acc_ch;
    assign data_wbyte  = bus_wdata;
    assign bus_rdata   = !(bus_sel && !bus_wr) ? 8'h00 :
                         acc_data ? data_rbyte[acc_ch] : ctrl_rdata_c[acc_ch];

    for (genvar c = 0; c < 2; c++) begin : g_chan
        assign ctrl_wr_c[c] = ctrl_acc && bus_wr && (acc_ch == c) && !rst_req_wr;
        assign ctrl_rd_c[c] = ctrl_acc && !bus_wr && (acc_ch == c);

        srb_chan_regs u_regs (
            .clk(clk), .rst_n(rst_n),
            .ctrl_wr(ctrl_wr_c[c]), .ctrl_rd(ctrl_rd_c[c]),
            .wdata(bus_wdata),
            .soft_rst(soft_req[c]), .hard_rst(hard_req),
            .wregs(chan_wregs[c]), .rr1(rr1_c[c]),
            .ptr(ptr_c[c]), .ctrl_rdata(ctrl_rdata_c[c])
        );

        srb_line_calc #(.DIV_W(DIV_W)) u_line (
            .clk(clk), .rst_n(rst_n),
            .clk_mode(chan_wregs[c][REG_FMT][7:6]),
            .par_en_bit(chan_wregs[c][REG_FMT][0]),
            .par_even_bit(chan_wregs[c][REG_FMT][1]),
            .stop_field(chan_wregs[c][REG_FMT][3:2]),
            .bits_field(chan_wregs[c][5][6:5]),
            .time_const({chan_wregs[c][REG_TC_HI], chan_wregs[c][REG_TC_LO]}),
            .data_bits(line_data_bits[c]),
            .parity_en(line_parity_en[c]),
            .parity_even(line_parity_even[c]),
            .two_stop(line_two_stop[c]),
            .div(line_div[c])
        );
    end
endmodule

// File: rtl/serial_regbank_chk.sv
module serial_regbank_chk (
    input logic                  clk,
    input logic                  rst_n,
    input logic [7:0]            bus_wdata,
    input logic [1:0]            ctrl_wr_c,
    input logic [1:0]            ctrl_rd_c,
    input logic [1:0]            soft_req,
    input logic [1:0][3:0]       ptr_c,
    input logic [1:0][7:0]       rr1_c,
    input logic [1:0][15:0][7:0] chan_wregs,
    input logic [1:0]            line_two_stop
);
    for (genvar c = 0; c < 2; c++) begin : g_chk
        a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr_c[c] && ptr_c[c] == 4'd0) |=>
            ptr_c[c] == {$past(bus_wdata[5:3]) == 3'b001, $past(bus_wdata[2:0])});

        a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_rd_c[c] |=> ptr_c[c] == 4'd0);

        a_r5_soft_masks: assert property (@(posedge clk) disable iff (!rst_n)
            soft_req[c] |=> (chan_wregs[c][15] == 8'hF8 && chan_wregs[c][0] == 8'h00
                             && ptr_c[c] == 4'd0));

        a_r8_all_sent: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr_c[c] && ptr_c[c] == 4'd4) |=> rr1_c[c][0]);

        a_r10_stop_follows: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> line_two_stop[c] == ($past(chan_wregs[c][4][3:2]) == 2'b11));
    end
endmodule

bind serial_regbank serial_regbank_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata),
    .ctrl_wr_c(ctrl_wr_c), .ctrl_rd_c(ctrl_rd_c), .soft_req(soft_req),
    .ptr_c(ptr_c), .rr1_c(rr1_c), .chan_wregs(chan_wregs),
    .line_two_stop(line_two_stop)
);

// File: tb/test_serial_regbank.sv
module test_serial_regbank;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, sw_sel = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [1:0][7:0] data_rbyte = '0;

    logic [7:0] bus_rdata, sw_rdata, data_wbyte, sw_wbyte;
    logic data_wr_stb, data_rd_stb, data_ch, sw_wr_stb, sw_rd_stb, sw_ch;
    logic [1:0][15:0][7:0] chan_wregs, sw_wregs;
    logic [1:0][3:0] line_data_bits, sw_bits;
    logic [1:0] line_parity_en, line_parity_even, line_two_stop, sw_pe, sw_pv, sw_ts;
    logic [1:0][22:0] line_div, sw_div;

    int checks = 0;
    int errors = 0;
    logic [7:0] sb_q[$];
    string sb_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_regbank i_serial_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .data_wr_stb(data_wr_stb), .data_rd_stb(data_rd_stb), .data_ch(data_ch),
        .data_wbyte(data_wbyte), .data_rbyte(data_rbyte), .chan_wregs(chan_wregs),
        .line_data_bits(line_data_bits), .line_parity_en(line_parity_en),
        .line_parity_even(line_parity_even), .line_two_stop(line_two_stop),
        .line_div(line_div)
    );

    serial_regbank #(.SWAP(1'b1)) i_swap_serial_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(sw_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(sw_rdata),
        .data_wr_stb(sw_wr_stb), .data_rd_stb(sw_rd_stb), .data_ch(sw_ch),
        .data_wbyte(sw_wbyte), .data_rbyte(data_rbyte), .chan_wregs(sw_wregs),
        .line_data_bits(sw_bits), .line_parity_en(sw_pe),
        .line_parity_even(sw_pv), .line_two_stop(sw_ts), .line_div(sw_div)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic ctrl_w(input logic ch, input logic [7:0] d);
        bus_write({2'b00, ch, 1'b0}, d);
    endtask

    // driver: push the expected byte, the monitor compares it
    task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        sb_q.push_back(exp);
        sb_tag.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ctrl_r(input logic ch, input logic [7:0] exp, input string tag);
        bus_read({2'b00, ch, 1'b0}, exp, tag);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (bus_sel && !bus_wr && sb_q.size() > 0)
                chk(sb_tag.pop_front(), 32'(bus_rdata), 32'(sb_q.pop_front()));
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 power-on state
        chk("R1 wregs zero", 32'(chan_wregs == '0), 32'd1);
        ctrl_r(1'b0, 8'h04, "R1 rr0 ch0");
        ctrl_r(1'b1, 8'h04, "R1 rr0 ch1");
        ctrl_w(1'b0, 8'h01);
        ctrl_r(1'b0, 8'h00, "R1 rr1 ch0");

        // R2 pointer load and point high
        ctrl_w(1'b0, 8'h0F);
        chk("R2 wr0 stored", 32'(chan_wregs[0][0]), 32'h0F);
        ctrl_w(1'b0, 8'h55);
        chk("R2 point high reg15", 32'(chan_wregs[0][15]), 32'h55);
        ctrl_w(1'b0, 8'h07);
        ctrl_w(1'b0, 8'h66);
        chk("R2 plain reg7", 32'(chan_wregs[0][7]), 32'h66);

        // R8 R10 R11 line format
        ctrl_w(1'b0, 8'h04); ctrl_w(1'b0, 8'hC1); settle();
        chk("R11 div x64 tc0", 32'(line_div[0]), 32'd128);
        chk("R10 parity en", 32'(line_parity_en[0]), 32'd1);
        chk("R10 parity odd", 32'(line_parity_even[0]), 32'd0);
        chk("R10 one stop", 32'(line_two_stop[0]), 32'd0);
        chk("R10 5 bits", 32'(line_data_bits[0]), 32'd5);
        ctrl_w(1'b0, 8'h01);
        ctrl_r(1'b0, 8'h01, "R8 all sent");
        ctrl_w(1'b0, 8'h0C); ctrl_w(1'b0, 8'h34);
        ctrl_w(1'b0, 8'h0D); ctrl_w(1'b0, 8'h12);
        ctrl_w(1'b0, 8'h05); ctrl_w(1'b0, 8'h40);
        ctrl_w(1'b0, 8'h04); ctrl_w(1'b0, 8'h4F); settle();
        chk("R11 div x16", 32'(line_div[0]), 32'h12360);
        chk("R10 6 bits", 32'(line_data_bits[0]), 32'd6);
        chk("R10 even", 32'(line_parity_even[0]), 32'd1);
        chk("R10 two stop", 32'(line_two_stop[0]), 32'd1);
        ctrl_w(1'b0, 8'h04); ctrl_w(1'b0, 8'h80); settle();
        chk("R11 div x32", 32'(line_div[0]), 32'h246C0);
        ctrl_w(1'b0, 8'h05); ctrl_w(1'b0, 8'h20); settle();
        chk("R10 7 bits", 32'(line_data_bits[0]), 32'd7);
        ctrl_w(1'b0, 8'h05); ctrl_w(1'b0, 8'h60);
        ctrl_w(1'b0, 8'h04); ctrl_w(1'b0, 8'h0C); settle();
        chk("R10 8 bits", 32'(line_data_bits[0]), 32'd8);
        chk("R11 div x1", 32'(line_div[0]), 32'h1236);
        ctrl_w(1'b0, 8'h0C);
        ctrl_r(1'b0, 8'h34, "R8 rr12 mirror");
        ctrl_w(1'b0, 8'h0D);
        ctrl_r(1'b0, 8'h12, "R8 rr13 mirror");

        // R3 pointer return
        ctrl_w(1'b0, 8'h01);
        ctrl_r(1'b0, 8'h01, "R3 read selected");
        ctrl_r(1'b0, 8'h04, "R3 read cleared pointer");
        ctrl_w(1'b0, 8'h02); ctrl_w(1'b0, 8'h99); ctrl_w(1'b0, 8'h77);
        chk("R3 wr2 stored", 32'(chan_wregs[0][2]), 32'h99);
        chk("R3 write returned pointer", 32'(chan_wregs[0][0]), 32'h77);
        ctrl_w(1'b0, 8'h00);
        ctrl_w(1'b0, 8'h05);
        ctrl_r(1'b0, 8'h00, "R3 unmapped read");

        // R9 hunt
        ctrl_w(1'b0, 8'h03); ctrl_w(1'b0, 8'h11);
        chk("R9 wr3", 32'(chan_wregs[0][3]), 32'h11);
        ctrl_r(1'b0, 8'h14, "R9 sync bit");

        // R4 data port and decode
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'b0011; bus_wdata = 8'hA5;
        #(CLK_PERIOD/4);
        chk("R4 data wr stb", 32'(data_wr_stb), 32'd1);
        chk("R4 data ch", 32'(data_ch), 32'd1);
        chk("R4 data byte", 32'(data_wbyte), 32'hA5);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        data_rbyte[0] = 8'h3C;
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 4'b0001;
        #(CLK_PERIOD/4);
        chk("R4 data rd stb", 32'(data_rd_stb), 32'd1);
        chk("R4 data rd byte", 32'(bus_rdata), 32'h3C);
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
        sw_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'b0010; bus_wdata = 8'h5A;
        #(CLK_PERIOD/4);
        chk("R4 swap data stb", 32'(sw_wr_stb), 32'd1);
        chk("R4 swap data ch", 32'(sw_ch), 32'd0);
        @(negedge clk);
        bus_addr = 4'b0001; bus_wdata = 8'h0F;
        @(negedge clk);
        sw_sel = 1'b0; bus_wr = 1'b0;
        chk("R4 swap ctrl ch1", 32'(sw_wregs[1][0]), 32'h0F);

        // channel 1 setup
        ctrl_w(1'b1, 8'h01); ctrl_w(1'b1, 8'hFF);
        ctrl_w(1'b1, 8'h0F); ctrl_w(1'b1, 8'h00);
        ctrl_w(1'b1, 8'h03); ctrl_w(1'b1, 8'h01);

        // R5 R7 soft reset of channel 1 from channel 0
        ctrl_w(1'b0, 8'h09); ctrl_w(1'b0, 8'h80);
        chk("R5 ch1 wr1", 32'(chan_wregs[1][1]), 32'h24);
        chk("R5 ch1 wr15", 32'(chan_wregs[1][15]), 32'hF8);
        chk("R5 ch1 wr3", 32'(chan_wregs[1][3]), 32'h00);
        chk("R5 ch1 wr4", 32'(chan_wregs[1][4]), 32'h04);
        chk("R5 ch1 wr0", 32'(chan_wregs[1][0]), 32'h00);
        chk("R7 reset byte not stored", 32'(chan_wregs[0][9]), 32'h00);
        ctrl_r(1'b1, 8'h44, "R5 ch1 rr0");
        ctrl_w(1'b0, 8'h03);
        chk("R7 writer pointer kept", 32'(chan_wregs[0][9]), 32'h03);

        // soft reset of channel 0 by itself
        ctrl_w(1'b0, 8'h09); ctrl_w(1'b0, 8'h40);
        chk("R5 ch0 wr3", 32'(chan_wregs[0][3]), 32'h10);
        chk("R5 ch0 wr5", 32'(chan_wregs[0][5]), 32'h60);
        ctrl_r(1'b0, 8'h54, "R7 pointer cleared, R5 rr0");

        // R6 hard reset
        ctrl_w(1'b1, 8'h09); ctrl_w(1'b1, 8'hC0);
        chk("R6 ch0 wr9", 32'(chan_wregs[0][9]), 32'hC3);
        chk("R6 ch1 wr9", 32'(chan_wregs[1][9]), 32'hC0);
        chk("R6 wr11", 32'(chan_wregs[1][11]), 32'h08);
        chk("R6 wr14", 32'(chan_wregs[0][14]), 32'h30);
        chk("R6 wr10", 32'(chan_wregs[0][10]), 32'h00);
        settle();
        chk("R6 line after hard", 32'(line_two_stop[0]), 32'd1);
        chk("R6 bits after hard", 32'(line_data_bits[0]), 32'd8);
        ctrl_w(1'b0, 8'h01);
        ctrl_r(1'b0, 8'h07, "R6 rr1");
        ctrl_r(1'b1, 8'h44, "R6 ch1 rr0");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule